// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This block watches the running calendar counters of a real-time clock and compares them with a bank of alarm registers. When the selected fields agree bit for bit, it raises an alarm flag. Three match modes are available. Daily compares only the time of day. Weekday compares the time of day and also requires the current weekday to be enabled in a seven-bit day mask. Dated compares the time of day, the date and the month. In every mode the year and weekday bits that share bytes with date and month are left out of the comparison.

The flag state machine has four states. ST_OFF means the alarm function is inactive. ST_ARMED means the block is waiting for a match. ST_FIRED means the flag is set. ST_SPENT means the flag was cleared while the match was still present. The transitions are:
- enable: ST_OFF to ST_ARMED, or to ST_FIRED if a match is already present.
- hit: ST_ARMED to ST_FIRED.
- clear: ST_FIRED to ST_ARMED, ST_SPENT or ST_OFF, depending on the match and enable.
- release: ST_SPENT to ST_ARMED when the match drops.
- disable: ST_ARMED or ST_SPENT to ST_OFF.

A set flag stays in ST_FIRED until software clears it. A match that persists therefore never triggers a second time.

The open-drain-style output `int_n` is active low. While the alarm enable is clear, it carries a 1 Hz square wave taken from the hundredths counter. Once the alarm is enabled, it signals the alarm flag and an external timer flag, each gated by its own enable bit in the control byte.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset, `alarm_flag` is 0 and `int_n` is 1.
- R2: No flag is raised while `alarm_en` is 0 or the mode field `alarm_ctl[5:4]` is 00, even when all fields match.
- R3: Daily mode (`alarm_ctl[5:4]`=01) compares all four time bytes (hours, minutes, seconds, hundredths) bit for bit. The date/year byte and the weekday/month byte are ignored. A single differing time bit prevents the match.
- R4: Dated mode (11) also compares the date (`cnt_yd[5:0]`) and the month (`cnt_wm[4:0]`). It ignores the year bits `[7:6]` and the weekday bits `[7:5]`.
- R5: Weekday mode (10) requires a time match and requires bit `alm_wkmap[cnt_wm[7:5]]` to be 1. A weekday value of 7 never matches.
- R6: The flag is set in the cycle after the match condition (enabled mode and equal fields) becomes true. It then holds. A persisting match does not set it again after a clear until the match has dropped and returned.
- R7: A `flag_clr` pulse while the flag is set clears it in the next cycle.
- R8: With `alarm_en`=1, `int_n` is 0 one cycle after (`alarm_flag` and `alarm_ctl[7]`) or (`timer_flag` and `alarm_ctl[3]`) holds, and 1 otherwise.
- R9: With `alarm_en`=0, `int_n` one cycle later is 1 when the hundredths byte `cnt_time[7:0]` is BCD 00–49, and 0 when it is 50–99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_en | input | 1 | Alarm function enable from the control/status register |
| alarm_ctl | input | 8 | Alarm control byte: [7] alarm interrupt enable, [5:4] mode, [3] timer interrupt enable |
| timer_flag | input | 1 | Flag from the timer |
| flag_clr | input | 1 | Software clear of the alarm flag |
| cnt_time | input | 32 | Counter bytes {hours, minutes, seconds, hundredths}, BCD |
| cnt_yd | input | 8 | Counter byte: [7:6] year, [5:0] date |
| cnt_wm | input | 8 | Counter byte: [7:5] weekday, [4:0] month |
| alm_time | input | 32 | Alarm time bytes, same layout as cnt_time |
| alm_yd | input | 8 | Alarm date byte, same layout as cnt_yd |
| alm_wm | input | 8 | Alarm month byte, same layout as cnt_wm |
| alm_wkmap | input | 7 | Weekday alarm mask, one bit per weekday 0..6 |
| alarm_flag | output | 1 | Alarm flag |
| int_n | output | 1 | Interrupt / square-wave output, active low |

## Verification
The comparator is tried with equal time bytes while the date byte and the month byte differ, which separates daily mode from dated mode. A single flipped minute bit shows that the compare is bit exact. Differing year and weekday bits under dated mode show those fields are masked.

Weekday tests set the current day's mask bit, clear only that bit, and use the out-of-range day 7. These cases tell the day-indexed lookup apart from any other mask reduction.

A match held across a clear, then dropped and restored, separates edge-triggered setting from level setting. Hundredths values on both sides of 50 confirm the square-wave phase.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    typedef enum logic [1:0] {
        MODE_NONE    = 2'b00,
        MODE_DAILY   = 2'b01,
        MODE_WEEKDAY = 2'b10,
        MODE_DATED   = 2'b11
    } alarm_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_ARMED = 2'b01,
        ST_FIRED = 2'b10,
        ST_SPENT = 2'b11
    } flag_state_e;

    localparam int CTL_W       = 8;
    localparam int CTL_AIE_BIT = 7;
    localparam int CTL_TIE_BIT = 3;
    localparam int CTL_MODE_LO = 4;

    localparam int DATE_W    = 6;
    localparam int MONTH_W   = 5;
    localparam int WDAY_LO   = 5;
    localparam int WDAY_W    = 3;
    localparam int NUM_DAYS  = 7;

endpackage

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int FIELD_W     = 8,
    parameter int TIME_FIELDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  alarm_mode_e                    mode,
    input  logic [FIELD_W*TIME_FIELDS-1:0] cnt_time,
    input  logic [FIELD_W-1:0]             cnt_yd,
    input  logic [FIELD_W-1:0]             cnt_wm,
    input  logic [FIELD_W*TIME_FIELDS-1:0] alm_time,
    input  logic [FIELD_W-1:0]             alm_yd,
    input  logic [FIELD_W-1:0]             alm_wm,
    input  logic [NUM_DAYS-1:0]            alm_wkmap,
    output logic                           match
);

    localparam int MAP_W = 1 << WDAY_W;

    logic [TIME_FIELDS-1:0] field_eq;
    logic                   time_eq;
    logic                   date_eq;
    logic                   day_ok;
    logic [WDAY_W-1:0]      wday;
    logic [MAP_W-1:0]       map_ext;
    logic                   masked_unused;

    // one comparator per time byte
    for (genvar g = 0; g < TIME_FIELDS; g++) begin : g_field
        assign field_eq[g] = (cnt_time[g*FIELD_W +: FIELD_W] ==
                              alm_time[g*FIELD_W +: FIELD_W]);
    end

    assign time_eq = &field_eq;
    assign date_eq = (cnt_yd[DATE_W-1:0]  == alm_yd[DATE_W-1:0]) &&
                     (cnt_wm[MONTH_W-1:0] == alm_wm[MONTH_W-1:0]);
    assign wday    = cnt_wm[WDAY_LO +: WDAY_W];
    assign map_ext = {{(MAP_W-NUM_DAYS){1'b0}}, alm_wkmap};
    assign day_ok  = map_ext[wday];

    // year and weekday bits of the alarm bytes take no part in a compare
    assign masked_unused = ^{alm_yd[FIELD_W-1:DATE_W], alm_wm[FIELD_W-1:MONTH_W]};

    always_comb begin
        unique case (mode)
            MODE_NONE:    match = 1'b0;
            MODE_DAILY:   match = time_eq;
            MODE_WEEKDAY: match = time_eq && day_ok;
            MODE_DATED:   match = time_eq && date_eq;
            default:      match = 1'b0;
        endcase
    end

    // R5: an out-of-range weekday can never produce a weekday match
    p_weekday7_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WEEKDAY && wday == WDAY_W'(NUM_DAYS)) |-> !match);

endmodule

// File: rtl/cal_alarm_flag_fsm.sv
module cal_alarm_flag_fsm
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic match,
    input  logic flag_clr,
    output logic flag
);

    flag_state_e state_q, state_d;
    logic        hit;

    assign hit = active && match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (hit)         state_d = ST_FIRED;   // enable with match
                else if (active) state_d = ST_ARMED;   // enable
            end
            ST_ARMED: begin
                if (!active)     state_d = ST_OFF;     // disable
                else if (match)  state_d = ST_FIRED;   // hit
            end
            ST_FIRED: begin
                if (flag_clr) begin                    // clear
                    if (hit)         state_d = ST_SPENT;
                    else if (active) state_d = ST_ARMED;
                    else             state_d = ST_OFF;
                end
            end
            ST_SPENT: begin
                if (!active)     state_d = ST_OFF;     // disable
                else if (!match) state_d = ST_ARMED;   // release
            end
            default:             state_d = ST_OFF;
        endcase
    end

    always_comb begin
        flag = (state_q == ST_FIRED);
    end

    // R6: a flag only rises after an enabled match was seen
    p_rise_needs_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));

    // R7: a clear while set drops the flag next cycle
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && flag_clr) |=> !flag);

    // R6: after a clear under a persisting match no re-trigger
    p_no_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && match) |=> !flag);

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
    import cal_alarm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alarm_en,
    input  logic               alarm_ie,
    input  logic               timer_ie,
    input  logic               alarm_flag,
    input  logic               timer_flag,
    input  logic [FIELD_W-1:0] hundredths,
    output logic               int_n
);

    localparam logic [FIELD_W-1:0] HALF_SEC = FIELD_W'(8'h50);

    logic wave_hi;
    logic int_n_d;
    logic int_n_q;

    assign wave_hi = (hundredths < HALF_SEC);

    always_comb begin
        if (alarm_en)
            int_n_d = !((alarm_flag && alarm_ie) || (timer_flag && timer_ie));
        else
            int_n_d = wave_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_n_q <= 1'b1;
        else        int_n_q <= int_n_d;
    end

    assign int_n = int_n_q;

    // R8: no source enabled keeps the pin released
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && !alarm_ie && !timer_ie) |=> int_n);

    // R9: first half-second drives the wave high
    p_wave_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && hundredths < HALF_SEC) |=> int_n);

    // R9: second half-second drives the wave low
    p_wave_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && hundredths >= HALF_SEC) |=> !int_n);

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int FIELD_W     = 8,
    parameter int TIME_FIELDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           alarm_en,
    input  logic [CTL_W-1:0]               alarm_ctl,
    input  logic                           timer_flag,
    input  logic                           flag_clr,
    input  logic [FIELD_W*TIME_FIELDS-1:0] cnt_time,
    input  logic [FIELD_W-1:0]             cnt_yd,
    input  logic [FIELD_W-1:0]             cnt_wm,
    input  logic [FIELD_W*TIME_FIELDS-1:0] alm_time,
    input  logic [FIELD_W-1:0]             alm_yd,
    input  logic [FIELD_W-1:0]             alm_wm,
    input  logic [NUM_DAYS-1:0]            alm_wkmap,
    output logic                           alarm_flag,
    output logic                           int_n
);

    alarm_mode_e mode;
    logic        active;
    logic        match;
    logic        ctl_unused;

    assign mode       = alarm_mode_e'(alarm_ctl[CTL_MODE_LO +: 2]);
    assign active     = alarm_en && (mode != MODE_NONE);
    assign ctl_unused = ^{alarm_ctl[6], alarm_ctl[2:0]};

    cal_alarm_match #(
        .FIELD_W     (FIELD_W),
        .TIME_FIELDS (TIME_FIELDS)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cnt_time  (cnt_time),
        .cnt_yd    (cnt_yd),
        .cnt_wm    (cnt_wm),
        .alm_time  (alm_time),
        .alm_yd    (alm_yd),
        .alm_wm    (alm_wm),
        .alm_wkmap (alm_wkmap),
        .match     (match)
    );

    cal_alarm_flag_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .match    (match),
        .flag_clr (flag_clr),
        .flag     (alarm_flag)
    );

    cal_alarm_irq #(
        .FIELD_W (FIELD_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_en   (alarm_en),
        .alarm_ie   (alarm_ctl[CTL_AIE_BIT]),
        .timer_ie   (alarm_ctl[CTL_TIE_BIT]),
        .alarm_flag (alarm_flag),
        .timer_flag (timer_flag),
        .hundredths (cnt_time[FIELD_W-1:0]),
        .int_n      (int_n)
    );

    // R2: an inactive alarm never raises a fresh flag
    p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !alarm_flag) |=> !alarm_flag);

endmodule

// File: tb/cal_alarm_cmp_tb.sv
module cal_alarm_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alarm_en = 1'b0;
    logic [7:0]  alarm_ctl = 8'h00;
    logic        timer_flag = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] cnt_time = 32'h12304510;
    logic [7:0]  cnt_yd = 8'h15;
    logic [7:0]  cnt_wm = 8'h66;
    logic [31:0] alm_time = 32'hFFFFFFFF;
    logic [7:0]  alm_yd = 8'h15;
    logic [7:0]  alm_wm = 8'h66;
    logic [6:0]  alm_wkmap = 7'h00;
    logic        alarm_flag;
    logic        int_n;

    int n_checks = 0;
    int n_fail = 0;

    localparam logic [31:0] T_REF = 32'h12304510;

    always #2 clk = ~clk;

    cal_alarm_cmp u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_en   (alarm_en),
        .alarm_ctl  (alarm_ctl),
        .timer_flag (timer_flag),
        .flag_clr   (flag_clr),
        .cnt_time   (cnt_time),
        .cnt_yd     (cnt_yd),
        .cnt_wm     (cnt_wm),
        .alm_time   (alm_time),
        .alm_yd     (alm_yd),
        .alm_wm     (alm_wm),
        .alm_wkmap  (alm_wkmap),
        .alarm_flag (alarm_flag),
        .int_n      (int_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ctl byte: aie at 7, mode at 5:4, tie at 3
    function automatic logic [7:0] ctl(input logic aie, input logic [1:0] m, input logic tie);
        return {aie, 1'b0, m, tie, 3'b000};
    endfunction

    task automatic quiesce();
        alm_time = 32'hFFFFFFFF;
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        step(2);
        check("R1 flag in reset", alarm_flag, 1'b0);
        check("R1 int_n in reset", int_n, 1'b1);
        rst_n = 1'b1;
        step(1);
        check("R1 flag after reset", alarm_flag, 1'b0);
        check("R1 int_n after reset", int_n, 1'b1);
    endtask

    task automatic t_inactive();
        alarm_en  = 1'b1;
        alarm_ctl = ctl(1'b1, 2'b00, 1'b0);
        cnt_time  = T_REF;
        alm_time  = T_REF;
        step(3);
        check("R2 mode none", alarm_flag, 1'b0);
        alm_time  = 32'hFFFFFFFF;
        step(1);
        alarm_en  = 1'b0;
        alarm_ctl = ctl(1'b1, 2'b01, 1'b0);
        alm_time  = T_REF;
        step(3);
        check("R2 alarm_en low", alarm_flag, 1'b0);
        quiesce();
    endtask

    task automatic t_daily();
        alarm_en  = 1'b1;
        alarm_ctl = ctl(1'b0, 2'b01, 1'b0);
        cnt_yd = 8'h15; cnt_wm = 8'h66;
        alm_yd = 8'hE2; alm_wm = 8'h11;
        alm_time = T_REF;
        step(1);
        check("R3 daily ignores date bytes", alarm_flag, 1'b1);
        quiesce();
        alm_time = T_REF ^ 32'h00010000;
        step(2);
        check("R3 one minute bit differs", alarm_flag, 1'b0);
        quiesce();
    endtask

    task automatic t_dated();
        alarm_en  = 1'b1;
        alarm_ctl = ctl(1'b0, 2'b11, 1'b0);
        cnt_yd = 8'h15; cnt_wm = 8'h66;
        alm_yd = 8'hD5; alm_wm = 8'h06;
        alm_time = T_REF;
        step(1);
        check("R4 dated ignores year/weekday", alarm_flag, 1'b1);
        quiesce();
        alm_wm = 8'h07;
        alm_time = T_REF;
        step(2);
        check("R4 month differs", alarm_flag, 1'b0);
        quiesce();
        alm_wm = 8'h06; alm_yd = 8'h16;
        alm_time = T_REF;
        step(2);
        check("R4 date differs", alarm_flag, 1'b0);
        quiesce();
        alm_yd = 8'h15;
    endtask

    task automatic t_weekday();
        alarm_en  = 1'b1;
        alarm_ctl = ctl(1'b0, 2'b10, 1'b0);
        cnt_wm = {3'd3, 5'h06};
        alm_wkmap = 7'b0001000;
        alm_time = T_REF;
        step(1);
        check("R5 day bit set", alarm_flag, 1'b1);
        quiesce();
        alm_wkmap = 7'b1110111;
        alm_time = T_REF;
        step(2);
        check("R5 day bit clear", alarm_flag, 1'b0);
        quiesce();
        cnt_wm = {3'd7, 5'h06};
        alm_wkmap = 7'h7F;
        alm_time = T_REF;
        step(2);
        check("R5 weekday 7", alarm_flag, 1'b0);
        quiesce();
        cnt_wm = 8'h66;
    endtask

    task automatic t_edge();
        alarm_en  = 1'b1;
        alarm_ctl = ctl(1'b0, 2'b01, 1'b0);
        alm_time = T_REF;
        step(5);
        check("R6 flag holds", alarm_flag, 1'b1);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        check("R7 clear", alarm_flag, 1'b0);
        step(5);
        check("R6 no re-trigger", alarm_flag, 1'b0);
        alm_time = 32'hFFFFFFFF;
        step(1);
        alm_time = T_REF;
        step(1);
        check("R6 new rising match", alarm_flag, 1'b1);
        quiesce();
    endtask

    task automatic t_irq();
        alarm_en  = 1'b1;
        alarm_ctl = ctl(1'b1, 2'b01, 1'b0);
        alm_time = T_REF;
        step(2);
        check("R8 alarm irq low", int_n, 1'b0);
        alarm_ctl = ctl(1'b0, 2'b01, 1'b0);
        step(1);
        check("R8 alarm irq masked", int_n, 1'b1);
        quiesce();
        timer_flag = 1'b1;
        alarm_ctl = ctl(1'b0, 2'b01, 1'b1);
        step(1);
        check("R8 timer irq low", int_n, 1'b0);
        alarm_ctl = ctl(1'b0, 2'b01, 1'b0);
        step(1);
        check("R8 timer irq masked", int_n, 1'b1);
        timer_flag = 1'b0;
    endtask

    task automatic t_wave();
        alarm_en = 1'b0;
        cnt_time = 32'h12304549;
        step(1);
        check("R9 hundredths 49", int_n, 1'b1);
        cnt_time = 32'h12304550;
        step(1);
        check("R9 hundredths 50", int_n, 1'b0);
        cnt_time = 32'h12304599;
        step(1);
        check("R9 hundredths 99", int_n, 1'b0);
        cnt_time = 32'h12304600;
        step(1);
        check("R9 hundredths 00", int_n, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_inactive();
                t_daily();
                t_dated();
                t_weekday();
                t_edge();
                t_irq();
                t_wave();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule